// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block holds the per-pin redirection table of an interrupt router and gives a host bus access to it through a pair of addresses. A host write to the selector address picks one internal register. Later reads and writes at the window address reach that register. Three small registers can be selected: a 4-bit identity field, a read-only version word and a read-only arbitration word. All remaining selector codes from 0x10 upward name one half of a 64-bit redirection entry.

The whole table is exported every cycle to the pin logic. The block also keeps a registered 256-bit map that shows which interrupt vectors any entry currently uses. Some table writes have side effects, and each of these gives a one-cycle pulse:
- a write that flips an entry's mask bit raises a mask-change pulse with the pin index;
- a write to a level-triggered entry whose pin is pending raises a service request.

The request port has no back-pressure. Every request presented with `req_valid` is accepted in that cycle. Each read returns exactly one response, marked by `rsp_valid` one cycle later. A write never produces a response. Byte lanes are not modelled: every access carries a full 32-bit word.

Top module: `irq_redir_window`

## Requirements
- R1: The selector sits at offset 0x00 and keeps the low 8 bits of the written word, which read back zero-extended. The window sits at offset 0x10. Any other offset reads as zero, and a write to it changes nothing.
- R2: A read accepted in one cycle gives `rsp_valid` high, with its data on `rsp_rdata`, in the next cycle. `rsp_valid` is low in a cycle that follows no read.
- R3: Selector 0x01 reads {8'h00, NUM_PINS-1, 8'h00, VERSION_ID}. Writes through the window with this selector are ignored.
- R4: Selector 0x00 reads and writes the identity in bits 27:24, with all other bits reading zero. Selector 0x02 reads the same identity field and ignores writes.
- R5: Selector s >= 0x10 reaches entry (s-0x10)>>1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, level trigger 15 (1 = level), mask 16, destination 63:56.
- R6: A window write whose entry index is NUM_PINS or more is dropped, and a read of such an index returns zero.
- R7: The bus cannot set remote-pending (bit 14). A low-half write clears it, a high-half write leaves it unchanged, and a pulse on `rirr_set[i]` sets it for entry i.
- R8: Bit v of `vec_map` is 1 exactly when some entry holds vector v. The map follows the table one cycle after each change.
- R9: Reset sets every entry to 64'h0000_0000_0001_0000 (masked, vector 0). It also clears the selector and the identity and sets the vector map to bit 0 only.
- R10: A window write that changes an entry's mask bit gives a one-cycle `mask_chg_valid` with the pin index and the new mask value. A write that leaves the mask unchanged gives no pulse.
- R11: After a write to either half of an entry, a one-cycle `svc_valid` with that pin index is raised if the written entry is level-triggered and `irr_in` for that pin is high. No pulse is raised otherwise.
- R12: `entries_o[64*i +: 64]` equals entry i at all times after the write that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irr_in | input | NUM_PINS | Pending state of each pin from the pin logic |
| rirr_set | input | NUM_PINS | Set remote-pending of an entry |
| entries_o | output | 64*NUM_PINS | Flattened redirection table |
| vec_map | output | 256 | Vectors used by the table |
| mask_chg_valid | output | 1 | Mask bit of an entry flipped |
| mask_chg_pin | output | IDX_W | Index of that entry |
| mask_chg_val | output | 1 | New mask value |
| svc_valid | output | 1 | Service request after an entry write |
| svc_pin | output | IDX_W | Pin of the service request |

## Verification
The remote-pending bit is the hardest state to reach, because the bus can never write it. Its only setter is the separate `rirr_set` input. The stimulus therefore pulses `rirr_set` for one entry and reads the low half back to see the bit set. It then writes the high half and checks that the bit survives, and finally writes the low half and checks that the bit clears. Service requests need the pending input and a level-triggered entry at the same moment as a window write. The bench holds `irr_in` high for chosen pins and then rewrites a level entry and an edge entry, and the edge entry must raise no request.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int ENTRY_W   = 64;
  localparam int MAP_W     = 256;
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;

  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] SEL_IDN  = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irw_table.sv
module irw_table
  import irw_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              wr_hi,
  input  logic [31:0]                       wr_data,
  input  logic [NUM_PINS-1:0]               rirr_set,
  input  logic [NUM_PINS-1:0]               irr_in,
  output logic [NUM_PINS-1:0][ENTRY_W-1:0]  tbl_q,
  output logic                              mask_chg_valid,
  output logic [IDX_W-1:0]                  mask_chg_pin,
  output logic                              mask_chg_val,
  output logic                              svc_valid,
  output logic [IDX_W-1:0]                  svc_pin
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl_d;
  logic [ENTRY_W-1:0] old_e, new_e;
  logic               pend_sel;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      tbl_d[i] = tbl_q[i];
      if (rirr_set[i]) tbl_d[i][RIRR_BIT] = 1'b1;
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        if (wr_hi) begin
          tbl_d[i][63:32] = wr_data;
        end else begin
          tbl_d[i][31:0]     = wr_data;
          tbl_d[i][RIRR_BIT] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    old_e    = '0;
    new_e    = '0;
    pend_sel = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (wr_idx == IDX_W'(i)) begin
        old_e    = tbl_q[i];
        new_e    = tbl_d[i];
        pend_sel = irr_in[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= ENTRY_RST;
      mask_chg_valid <= 1'b0;
      mask_chg_pin   <= '0;
      mask_chg_val   <= 1'b0;
      svc_valid      <= 1'b0;
      svc_pin        <= '0;
    end else begin
      tbl_q          <= tbl_d;
      mask_chg_valid <= wr_en && (old_e[MASK_BIT] != new_e[MASK_BIT]);
      mask_chg_pin   <= wr_idx;
      mask_chg_val   <= new_e[MASK_BIT];
      svc_valid      <= wr_en && new_e[TRIG_BIT] && pend_sel;
      svc_pin        <= wr_idx;
    end
  end
endmodule

// File: rtl/irw_vecmap.sv
module irw_vecmap
  import irw_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PINS-1:0][ENTRY_W-1:0]  tbl,
  output logic [MAP_W-1:0]                  vec_map
);
  logic [NUM_PINS-1:0][MAP_W-1:0] onehot;
  logic [MAP_W-1:0]               map_d;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
    assign onehot[g] = MAP_W'(1) << tbl[g][VEC_LSB +: VEC_W];
  end

  always_comb begin
    map_d = '0;
    for (int i = 0; i < NUM_PINS; i++) map_d = map_d | onehot[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vec_map <= MAP_W'(1);
    else        vec_map <= map_d;
  end
endmodule

// File: rtl/irw_readmux.sv
module irw_readmux
  import irw_pkg::*;
#(
  parameter int         NUM_PINS   = 24,
  parameter int         IDX_W      = 5,
  parameter logic [7:0] VERSION_ID = 8'h11
) (
  input  logic [7:0]                        addr,
  input  logic [7:0]                        sel,
  input  logic [3:0]                        idn,
  input  logic                              tbl_hit,
  input  logic [IDX_W-1:0]                  tbl_idx,
  input  logic                              tbl_hi,
  input  logic [NUM_PINS-1:0][ENTRY_W-1:0]  tbl,
  output logic [31:0]                       rdata
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);
  logic [ENTRY_W-1:0] ent;

  always_comb begin
    ent = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (tbl_idx == IDX_W'(i)) ent = tbl[i];
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_SEL) begin
      rdata = {24'h0, sel};
    end else if (addr == OFF_WIN) begin
      if (sel == SEL_VER)                       rdata = {8'h00, MAX_PIN, 8'h00, VERSION_ID};
      else if (sel == SEL_IDN || sel == SEL_ARB) rdata = {4'h0, idn, 24'h0};
      else if (tbl_hit)                          rdata = tbl_hi ? ent[63:32] : ent[31:0];
    end
  end
endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window
  import irw_pkg::*;
#(
  parameter int         NUM_PINS   = 24,
  parameter logic [7:0] VERSION_ID = 8'h11,
  localparam int        IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [7:0]                   req_addr,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_valid,
  output logic [31:0]                  rsp_rdata,
  input  logic [NUM_PINS-1:0]          irr_in,
  input  logic [NUM_PINS-1:0]          rirr_set,
  output logic [NUM_PINS*64-1:0]       entries_o,
  output logic [255:0]                 vec_map,
  output logic                         mask_chg_valid,
  output logic [IDX_W-1:0]             mask_chg_pin,
  output logic                         mask_chg_val,
  output logic                         svc_valid,
  output logic [IDX_W-1:0]             svc_pin
);
  logic [7:0]  sel_q;
  logic [3:0]  idn_q;
  logic [7:0]  sel_off;
  logic [6:0]  idx_full;
  logic        tbl_hit, tbl_hi, win_wr, tbl_wr;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0] rd_comb;
  logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl;

  assign sel_off  = sel_q - SEL_TBL;
  assign idx_full = sel_off[7:1];
  assign tbl_hi   = sel_off[0];
  assign tbl_hit  = (sel_q >= SEL_TBL) && ({1'b0, idx_full} < 8'(NUM_PINS));
  assign tbl_idx  = IDX_W'(idx_full);
  assign win_wr   = req_valid && req_write && (req_addr == OFF_WIN);
  assign tbl_wr   = win_wr && tbl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      idn_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (req_valid && req_write && req_addr == OFF_SEL) sel_q <= req_wdata[7:0];
      if (win_wr && sel_q == SEL_IDN) idn_q <= req_wdata[27:24];
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_comb;
    end
  end

  irw_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_hi(tbl_hi), .wr_data(req_wdata),
    .rirr_set(rirr_set), .irr_in(irr_in), .tbl_q(tbl),
    .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
    .mask_chg_val(mask_chg_val), .svc_valid(svc_valid), .svc_pin(svc_pin)
  );

  irw_vecmap #(.NUM_PINS(NUM_PINS)) u_vecmap (
    .clk(clk), .rst_n(rst_n), .tbl(tbl), .vec_map(vec_map)
  );

  irw_readmux #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .VERSION_ID(VERSION_ID)) u_rdmux (
    .addr(req_addr), .sel(sel_q), .idn(idn_q), .tbl_hit(tbl_hit),
    .tbl_idx(tbl_idx), .tbl_hi(tbl_hi), .tbl(tbl), .rdata(rd_comb)
  );

  assign entries_o = tbl;
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int         NUM_PINS   = 24,
  parameter logic [7:0] VERSION_ID = 8'h11,
  parameter int         IDX_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [7:0]       req_addr,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [7:0]       sel_q,
  input logic [255:0]     vec_map,
  input logic             mask_chg_valid,
  input logic [IDX_W-1:0] mask_chg_pin,
  input logic             svc_valid,
  input logic [IDX_W-1:0] svc_pin
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_ID};

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R2
  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 8'h10 && sel_q == 8'h01) |=> (rsp_rdata == VER_WORD)); // R3
  AST_MASK_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> $past(req_valid && req_write && req_addr == 8'h10)); // R10
  AST_MASK_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> ({1'b0, mask_chg_pin} < (IDX_W+1)'(NUM_PINS))); // R6
  AST_SVC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> ($past(req_valid && req_write && req_addr == 8'h10) && ({1'b0, svc_pin} < (IDX_W+1)'(NUM_PINS)))); // R11
  AST_MAP_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vec_map) >= 1); // R8
endmodule

bind irq_redir_window irw_checker #(.NUM_PINS(NUM_PINS), .VERSION_ID(VERSION_ID), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .sel_q(sel_q), .vec_map(vec_map), .mask_chg_valid(mask_chg_valid),
  .mask_chg_pin(mask_chg_pin), .svc_valid(svc_valid), .svc_pin(svc_pin)
);

// File: tb/irq_redir_window_bench.sv
module irq_redir_window_bench;
  localparam int NP = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] irr_in = '0, rirr_set = '0;
  logic [NP*64-1:0] entries_o;
  logic [255:0] vec_map;
  logic mask_chg_valid, mask_chg_val, svc_valid;
  logic [IW-1:0] mask_chg_pin, svc_pin;

  int checks = 0;
  int fails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_redir_window #(.NUM_PINS(NP), .VERSION_ID(8'h11)) u_irq_redir_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irr_in(irr_in), .rirr_set(rirr_set),
    .entries_o(entries_o), .vec_map(vec_map), .mask_chg_valid(mask_chg_valid),
    .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val),
    .svc_valid(svc_valid), .svc_pin(svc_pin)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 8'd9},   // R9 selector clear
    '{1'b1, 8'h00, 32'h1, 32'h0, 8'd1},
    '{1'b0, 8'h10, 32'h0, 32'h0017_0011, 8'd3},   // R3 version word
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd3},
    '{1'b0, 8'h10, 32'h0, 32'h0017_0011, 8'd3},   // R3 write ignored
    '{1'b0, 8'h00, 32'h0, 32'h0000_0001, 8'd1},   // R1 selector readback
    '{1'b1, 8'h00, 32'h0, 32'h0, 8'd4},
    '{1'b0, 8'h10, 32'h0, 32'h0000_0000, 8'd9},   // R9 identity clear
    '{1'b1, 8'h10, 32'hA500_0000, 32'h0, 8'd4},
    '{1'b0, 8'h10, 32'h0, 32'h0500_0000, 8'd4},   // R4 identity write
    '{1'b1, 8'h00, 32'h2, 32'h0, 8'd4},
    '{1'b1, 8'h10, 32'h0F00_0000, 32'h0, 8'd4},
    '{1'b0, 8'h10, 32'h0, 32'h0500_0000, 8'd4},   // R4 arbitration read-only
    '{1'b1, 8'h00, 32'h12, 32'h0, 8'd5},
    '{1'b0, 8'h10, 32'h0, 32'h0001_0000, 8'd9},   // R9 mask set
    '{1'b1, 8'h10, 32'h0000_A935, 32'h0, 8'd5},
    '{1'b0, 8'h10, 32'h0, 32'h0000_A935, 8'd5},   // R5 low half
    '{1'b1, 8'h00, 32'h13, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'hC300_0000, 32'h0, 8'd5},
    '{1'b0, 8'h10, 32'h0, 32'hC300_0000, 8'd5},   // R5 high half
    '{1'b1, 8'h00, 32'h40, 32'h0, 8'd6},
    '{1'b1, 8'h10, 32'h1234_5678, 32'h0, 8'd6},
    '{1'b0, 8'h10, 32'h0, 32'h0000_0000, 8'd6},   // R6 out of range
    '{1'b1, 8'h00, 32'h3F, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0, 8'd5},
    '{1'b0, 8'h10, 32'h0, 32'hDEAD_BEEF, 8'd5},   // R5 last pin
    '{1'b0, 8'h20, 32'h0, 32'h0000_0000, 8'd1},   // R1 other offset
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0, 8'd1},
    '{1'b0, 8'h00, 32'h0, 32'h0000_003F, 8'd1},   // R1 write elsewhere ignored
    '{1'b1, 8'h00, 32'h0000_01AB, 32'h0, 8'd1},
    '{1'b0, 8'h00, 32'h0, 32'h0000_00AB, 8'd1},   // R1 8-bit selector
    '{1'b1, 8'h00, 32'h14, 32'h0, 8'd7},
    '{1'b1, 8'h10, 32'h0000_4020, 32'h0, 8'd7},
    '{1'b0, 8'h10, 32'h0, 32'h0000_0020, 8'd7}    // R7 bus cannot set
  };

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", 256'(rsp_valid), 256'(1));
    d = rsp_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state at the ports
    chk("R9 entry0 reset", 256'(entries_o[63:0]), 256'(64'h0000_0000_0001_0000));
    chk("R9 entry23 reset", 256'(entries_o[23*64 +: 64]), 256'(64'h0000_0000_0001_0000));
    chk("R8 map after reset", vec_map, 256'(1));
    chk("R2 no rsp idle", 256'(rsp_valid), 256'(0));

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, rd);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), 256'(rd), 256'(VECS[i].exp));
      end
    end

    @(negedge clk);
    chk("R8 map contents", vec_map, (256'(1)) | (256'(1) << 8'h20) | (256'(1) << 8'h35));
    chk("R12 entry1 export", 256'(entries_o[64 +: 64]), 256'(64'hC300_0000_0000_A935));

    // R10 mask flip on entry3
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'h0000_0050);
    chk("R10 pulse", 256'({mask_chg_valid, mask_chg_pin, mask_chg_val}), 256'({1'b1, 5'd3, 1'b0}));
    bus_wr(8'h10, 32'h0000_0051);
    chk("R10 no pulse", 256'(mask_chg_valid), 256'(0));
    bus_wr(8'h10, 32'h0001_0051);
    chk("R10 remask", 256'({mask_chg_valid, mask_chg_pin, mask_chg_val}), 256'({1'b1, 5'd3, 1'b1}));

    // R7 remote-pending on entry1
    @(negedge clk); rirr_set = 24'h2;
    @(negedge clk); rirr_set = '0;
    bus_wr(8'h00, 32'h12);
    bus_rd(8'h10, rd);
    chk("R7 set by input", 256'(rd), 256'(32'h0000_E935));
    bus_wr(8'h00, 32'h13);
    bus_wr(8'h10, 32'hC300_0000);
    bus_wr(8'h00, 32'h12);
    bus_rd(8'h10, rd);
    chk("R7 high write keeps", 256'(rd), 256'(32'h0000_E935));
    bus_wr(8'h10, 32'h0000_A935);
    bus_rd(8'h10, rd);
    chk("R7 low write clears", 256'(rd), 256'(32'h0000_A935));

    // R11 service requests
    irr_in = 24'h00000A;
    bus_wr(8'h10, 32'h0000_A935);
    chk("R11 level pending", 256'({svc_valid, svc_pin}), 256'({1'b1, 5'd1}));
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'h0000_0050);
    chk("R11 edge no svc", 256'(svc_valid), 256'(0));
    bus_wr(8'h00, 32'h13);
    bus_wr(8'h10, 32'hC300_0000);
    chk("R11 high half", 256'({svc_valid, svc_pin}), 256'({1'b1, 5'd1}));
    irr_in = '0;
    bus_wr(8'h10, 32'hC300_0000);
    chk("R11 not pending", 256'(svc_valid), 256'(0));

    // R9 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 entry1 masked again", 256'(entries_o[64 +: 64]), 256'(64'h0000_0000_0001_0000));
    chk("R8 map restored", vec_map, 256'(1));
    bus_rd(8'h00, rd);
    chk("R9 selector", 256'(rd), 256'(0));
    bus_rd(8'h10, rd);
    chk("R9 identity", 256'(rd), 256'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule